// File: doc/BRIEF.md
# Sequential Half-Word Multiply-Accumulate Multiplier

This block produces 32-bit multiply results for the integer multiply instructions of a 32-bit processor: the low word of the product, or the high word with either operand taken as signed or unsigned. It has one 17x17-bit signed multiplier feeding a 34-bit accumulator. A short state machine steps that single unit through the half-word partial products, low×low first, then low×high, high×low and finally high×high. No adder outside the block is used.

A request is accepted when `start_i` is high while the block is idle. The operands, operator and sign-mode bits are captured on that edge. After the low×low step the bottom 16 result bits are kept aside and the accumulator moves down by 16 bits. A low-word request ends after the high×low step. A high-word request takes one more step, in which the accumulator moves down again with sign extension and the high×high product is added. The result appears together with a one-cycle `valid_o` pulse. The block then returns to idle and can accept the next request in the following cycle.

Top module: `mac_mul_seq`

## Requirements
- R1: With `op_i`=0 (low word), the result equals bits 31:0 of the product `a_i`×`b_i`.
- R2: With `op_i`=1 (high word), the result equals bits 63:32 of the 64-bit product. `sgn_i[0]`=1 treats `a_i` as two's-complement and `sgn_i[0]`=0 treats it as unsigned. `sgn_i[1]` does the same for `b_i`.
- R3: For a low-word request accepted at clock edge 0, `valid_o` is low after edge 1 and high after edge 2, so the request takes 3 cycles in total.
- R4: For a high-word request accepted at clock edge 0, `valid_o` is low after edges 1 and 2 and high after edge 3, so the request takes 4 cycles in total.
- R5: `valid_o` is high for exactly one cycle per request, and `result_o` is zero whenever `valid_o` is low.
- R6: While a request is in progress, `start_i` and any change of `a_i`, `b_i`, `op_i` or `sgn_i` have no effect on the result. Such a request is not queued, so no extra `valid_o` pulse follows.
- R7: During reset `valid_o` and `result_o` are 0, and a request raised in the first cycle after reset release is accepted.
- R8: A request raised in the cycle right after a `valid_o` pulse is accepted, so requests can follow one another without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only while idle |
| op_i | input | 1 | 0: low word of product, 1: high word |
| sgn_i | input | 2 | bit 0: `a_i` signed, bit 1: `b_i` signed |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| result_o | output | 32 | Selected product word, zero when not valid |
| valid_o | output | 1 | One-cycle pulse with the result |

## Verification
The bench builds the block with its default half-word width of 16, which gives 32-bit operands and exercises the shift-by-16 accumulator path exactly as the 32-bit instructions need it. At that width the sign corners can be reached directly: most-negative times most-negative, all-ones unsigned, and mixed signed/unsigned high words, where a wrong sign extension of an upper half or of the shifted accumulator changes the high word. The latency checks pin down the 3- and 4-cycle counts. The remaining tests cover requests that run back to back and inputs that change while a request is in progress.

// File: rtl/mac_mul_pkg.sv
package mac_mul_pkg;
  // partial-product step: first letter operand a half, second operand b half
  typedef enum logic [1:0] {
    ST_LL = 2'd0,  // idle / low x low
    ST_LH = 2'd1,
    ST_HL = 2'd2,
    ST_HH = 2'd3
  } mac_step_e;

  typedef enum logic {
    OP_LOW  = 1'b0,
    OP_HIGH = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_mul_ctrl.sv
module mac_mul_ctrl
  import mac_mul_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      op_i,
  output mac_step_e step_o,
  output logic      accept_o,
  output logic      valid_o
);
  mac_step_e step_q, step_d;
  mac_op_e   op_q;

  assign accept_o = (step_q == ST_LL) && start_i;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_LL: if (start_i) step_d = ST_LH;
      ST_LH: step_d = ST_HL;
      ST_HL: step_d = (op_q == OP_HIGH) ? ST_HH : ST_LL;
      ST_HH: step_d = ST_LL;
      default: step_d = ST_LL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_LL;
      op_q   <= OP_LOW;
    end else begin
      step_q <= step_d;
      if (accept_o) op_q <= mac_op_e'(op_i);
    end
  end

  assign valid_o = ((step_q == ST_HL) && (op_q == OP_LOW)) || (step_q == ST_HH);
  assign step_o  = step_q;
endmodule

// File: rtl/mac_mul_unit.sv
module mac_mul_unit #(
  parameter  int MAC_W = 17,
  localparam int ACC_W = 2 * MAC_W
) (
  input  logic signed [MAC_W-1:0] a_i,
  input  logic signed [MAC_W-1:0] b_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [ACC_W-1:0] a_x, b_x;

  assign a_x   = {{MAC_W{a_i[MAC_W-1]}}, a_i};
  assign b_x   = {{MAC_W{b_i[MAC_W-1]}}, b_i};
  assign sum_o = acc_i + a_x * b_x;
endmodule

// File: rtl/mac_mul_seq.sv
module mac_mul_seq
  import mac_mul_pkg::*;
#(
  parameter  int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [1:0]        sgn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int MAC_W = HALF_W + 1;
  localparam int ACC_W = 2 * MAC_W;

  mac_step_e step;
  logic      accept, valid;

  logic [DATA_W-1:0] a_q, b_q, a_s, b_s;
  logic [1:0]        sgn_q, sgn_s;
  logic [HALF_W-1:0] low_q;
  logic signed [ACC_W-1:0] acc_q, acc_in, sum, acc_sh;
  logic signed [MAC_W-1:0] mac_a, mac_b;
  logic signed [MAC_W-1:0] half_a [2];
  logic signed [MAC_W-1:0] half_b [2];

  mac_mul_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .step_o   (step),
    .accept_o (accept),
    .valid_o  (valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= '0;
    end else if (accept) begin
      a_q   <= a_i;
      b_q   <= b_i;
      sgn_q <= sgn_i;
    end
  end

  // first step works on the live inputs, later steps on the captured copy
  assign a_s   = (step == ST_LL) ? a_i   : a_q;
  assign b_s   = (step == ST_LL) ? b_i   : b_q;
  assign sgn_s = (step == ST_LL) ? sgn_i : sgn_q;

  // index 0: low half, zero-extended; index 1: high half, sign-extended on demand
  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign half_a[h] = {1'b0, a_s[HALF_W-1:0]};
      assign half_b[h] = {1'b0, b_s[HALF_W-1:0]};
    end else begin : g_hi
      assign half_a[h] = {sgn_s[0] & a_s[DATA_W-1], a_s[DATA_W-1:HALF_W]};
      assign half_b[h] = {sgn_s[1] & b_s[DATA_W-1], b_s[DATA_W-1:HALF_W]};
    end
  end

  always_comb begin
    mac_a = half_a[0];
    mac_b = half_b[0];
    unique case (step)
      ST_LL: begin mac_a = half_a[0]; mac_b = half_b[0]; end
      ST_LH: begin mac_a = half_a[0]; mac_b = half_b[1]; end
      ST_HL: begin mac_a = half_a[1]; mac_b = half_b[0]; end
      ST_HH: begin mac_a = half_a[1]; mac_b = half_b[1]; end
      default: ;
    endcase
  end

  assign acc_in = (step == ST_LL) ? '0 : acc_q;

  mac_mul_unit #(.MAC_W(MAC_W)) u_mac (
    .a_i   (mac_a),
    .b_i   (mac_b),
    .acc_i (acc_in),
    .sum_o (sum)
  );

  assign acc_sh = sum >>> HALF_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      low_q <= '0;
    end else if (accept) begin
      acc_q <= acc_sh;
      low_q <= sum[HALF_W-1:0];
    end else begin
      unique case (step)
        ST_LH:   acc_q <= sum;
        ST_HL:   acc_q <= acc_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    result_o = '0;
    if (valid) begin
      if (step == ST_HH) result_o = sum[DATA_W-1:0];
      else               result_o = {sum[HALF_W-1:0], low_q};
    end
  end

  assign valid_o = valid;
endmodule

// File: rtl/mac_mul_chk.sv
module mac_mul_chk #(
  parameter  int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              op_i,
  input logic [1:0]        sgn_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o
);
  logic              busy_q;
  logic [DATA_W-1:0] exp_q;
  logic [2*DATA_W-1:0] xa, xb, prod;

  assign xa   = sgn_i[0] ? {{DATA_W{a_i[DATA_W-1]}}, a_i} : {{DATA_W{1'b0}}, a_i};
  assign xb   = sgn_i[1] ? {{DATA_W{b_i[DATA_W-1]}}, b_i} : {{DATA_W{1'b0}}, b_i};
  assign prod = xa * xb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      exp_q  <= '0;
    end else if (busy_q) begin
      busy_q <= !valid_o;
    end else if (start_i) begin
      busy_q <= 1'b1;
      exp_q  <= op_i ? prod[2*DATA_W-1:DATA_W] : prod[DATA_W-1:0];
    end
  end

  // R3
  lo_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && !op_i) |=> !valid_o ##1 valid_o);

  // R4
  hi_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && op_i) |=> !valid_o ##1 !valid_o ##1 valid_o);

  // R5
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R5
  quiet_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> result_o == '0);

  // R6
  no_stray_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> busy_q);

  // R1 R2
  product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> result_o == exp_q);
endmodule

bind mac_mul_seq mac_mul_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .sgn_i    (sgn_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/sim_mac_mul_seq.sv
`timescale 1ns/1ps
module sim_mac_mul_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  sgn_i = 2'b00;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mac_mul_seq u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .sgn_i    (sgn_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni  = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R7 valid in reset", 64'(valid_o), 64'h0);
    chk(result_o == 32'h0, "R7 result in reset", 64'(result_o), 64'h0);
    rst_ni = 1'b1;
  endtask

  // called at a negedge; leaves at the negedge after the pulse, ready for back-to-back use
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic op,
                        input logic [1:0] sg, input string req);
    logic [63:0] xa, xb, p;
    logic [31:0] exp;
    int k;
    xa  = sg[0] ? {{32{a[31]}}, a} : {32'h0, a};
    xb  = sg[1] ? {{32{b[31]}}, b} : {32'h0, b};
    p   = xa * xb;
    exp = op ? p[63:32] : p[31:0];
    a_i = a; b_i = b; op_i = op; sgn_i = sg; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k = 1;
    while (!valid_o && k < 8) begin
      @(negedge clk_i);
      k++;
    end
    if (op) chk(k == 3, "R4 latency", 64'(k), 64'd3);
    else    chk(k == 2, "R3 latency", 64'(k), 64'd2);
    chk(result_o == exp, req, 64'(result_o), 64'(exp));
    @(negedge clk_i);
    chk(!valid_o && result_o == 32'h0, "R5 pulse end", {31'h0, valid_o, result_o}, 64'h0);
  endtask

  // R6: start held and inputs changed while busy
  task automatic t_ignore();
    int k;
    a_i = 32'd7; b_i = 32'd9; op_i = 1'b0; sgn_i = 2'b00; start_i = 1'b1;
    @(negedge clk_i);
    a_i = 32'hDEAD_BEEF; b_i = 32'h8000_0001; op_i = 1'b1; sgn_i = 2'b11;
    k = 1;
    while (!valid_o && k < 8) begin
      @(negedge clk_i);
      k++;
    end
    chk(k == 2, "R6 latency kept", 64'(k), 64'd2);
    chk(result_o == 32'd63, "R6 captured operands", 64'(result_o), 64'd63);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R6 no second pulse", 64'(valid_o), 64'h0);
    k = 0;
    repeat (5) begin
      @(negedge clk_i);
      if (valid_o) k++;
    end
    chk(k == 0, "R6 request not queued", 64'(k), 64'h0);
  endtask

  initial begin
    t_reset();
    // R7: first request right after reset release
    run_op(32'd3, 32'd5, 1'b0, 2'b00, "R7 R1 first request");
    // R8: the following calls start in the cycle after each pulse
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 2'b00, "R8 R1 unsigned low");
    run_op(32'hFFFF_FFF9, 32'd13, 1'b0, 2'b11, "R1 signed low");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'b00, "R1 all ones low");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 2'b11, "R2 signed min x min");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b11, "R2 signed -1 x -1");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b00, "R2 unsigned all ones");
    run_op(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b1, 2'b01, "R2 signed x unsigned");
    run_op(32'h7FFF_1234, 32'h8000_ABCD, 1'b1, 2'b11, "R2 mixed halves signed");
    run_op(32'hC350_0000, 32'h0001_86A0, 1'b1, 2'b10, "R2 unsigned x signed");
    run_op(32'h0, 32'hFFFF_FFFF, 1'b1, 2'b11, "R2 zero operand");
    t_ignore();
    run_op(32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 2'b00, "R2 carry across halves");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule